// File: doc/BRIEF.md
# Timer/Counter with Shared Watchdog Prescaler

This block pairs an 8-bit timer/counter with a watchdog counter, and the two share one programmable power-of-two prescaler. An 8-bit mode register sets four things: the division ratio, which counter owns the prescaler, whether the timer counts internal instruction-cycle ticks or transitions on an external pin, and which edge of that pin counts. Software can read and write the timer through a plain register port. A flag goes high when the timer wraps from its maximum value to zero, and it stays high until it is cleared.

The watchdog advances on a separate slow tick. When that tick goes through the prescaler, the watchdog advances on the prescaler output instead. When the watchdog counter runs out, the block issues a one-cycle reset pulse, records a timeout in a status bit and puts the mode register back to its reset value. A clear strobe restarts the watchdog. A sleep strobe also restarts it and records a power-down in a second status bit.

Top module: `tmr_wdt_top`

## Requirements
- R1: After reset, mode_o reads 0xFF, tmr_o is 0, ovf_flag_o and wdt_rst_o are 0, and to_n_o and pd_n_o are 1.
- R2: The mode register is loaded from mode_wdata_i when mode_we_i is high and is read on mode_o. Its fields are: bits [2:0] ratio code k; bit 3 owner (0 = timer, 1 = watchdog); bit 4 edge (0 = rising, 1 = falling); bit 5 source (0 = icyc_tick_i, 1 = external pin).
- R3: When the timer owns the prescaler, the timer advances once every 2^(k+1) source events, so code 0 gives 1:2 and code 7 gives 1:256.
- R4: When the watchdog owns the prescaler, the timer advances once on every source event.
- R5: With source = external, ext_pin_i passes through a two-flop synchronizer. Only the edge selected by bit 4 counts; the other edge is ignored.
- R6: A timer write loads tmr_wdata_i and takes priority over an increment in the same cycle. Every timer write also clears the prescaler count.
- R7: ovf_flag_o is set when the timer wraps from 0xFF to 0x00 and stays set until ovf_clr_i. A set takes priority over a clear in the same cycle.
- R8: When the watchdog owns the prescaler, the watchdog advances once every 2^k wdt_tick_i pulses. When the timer owns the prescaler, the watchdog advances on every wdt_tick_i pulse.
- R9: The watchdog times out on an advance at count 2^WDT_W-1. On the following edge, wdt_rst_o is high for exactly one cycle, to_n_o goes to 0 and mode_o returns to 0xFF.
- R10: clr_wdt_i zeroes the watchdog counter, and also the prescaler when the watchdog owns it. It sets to_n_o and pd_n_o to 1. A timeout in the same cycle is cancelled.
- R11: sleep_i zeroes the watchdog counter, and also the prescaler when the watchdog owns it. It sets to_n_o to 1 and pd_n_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| icyc_tick_i | input | 1 | Internal instruction-cycle tick |
| ext_pin_i | input | 1 | External timer input, asynchronous |
| wdt_tick_i | input | 1 | Slow watchdog tick |
| clr_wdt_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep command strobe |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | 8 | Mode register write data |
| mode_o | output | 8 | Mode register contents |
| tmr_we_i | input | 1 | Timer write enable |
| tmr_wdata_i | input | TMR_W | Timer write data |
| tmr_o | output | TMR_W | Timer value |
| ovf_clr_i | input | 1 | Overflow flag clear |
| ovf_flag_o | output | 1 | Timer overflow flag |
| wdt_rst_o | output | 1 | Watchdog timeout reset pulse |
| to_n_o | output | 1 | Low after a watchdog timeout |
| pd_n_o | output | 1 | Low after a sleep command |

## Verification
Two pairs of events are provoked in the same cycle, and each time the bench checks the expected winner.

The first pair is the watchdog timeout and the clear strobe. The counter is brought to its last count, and the final tick arrives together with clr_wdt_i. The bench checks that no reset pulse appears, and that a full window of ticks is then needed before the next pulse.

The second pair is a timer increment and a timer write, driven on the same edge. The bench checks that the written value is what remains. The overflow wrap is also lined up with ovf_clr_i, and the bench checks that the flag stays set.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;
  typedef struct packed {
    logic [1:0] spare;
    logic       src_ext;   // 1: external pin events
    logic       fall_edge; // 1: count high-to-low
    logic       pre_wdt;   // 1: prescaler owned by watchdog
    logic [2:0] ps;
  } mode_t;

  localparam logic [7:0] MODE_RST = 8'hFF;
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign edge_o = fall_sel_i ? (sh_q[2] & ~sh_q[1]) : (~sh_q[2] & sh_q[1]);

  AST_EDGE_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (sh_q[1] != sh_q[2])) else $error("edge without level change"); // R5
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int PRE_W = 8,
  localparam int SH_W = $clog2(PRE_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ev_i,
  input  logic            clr_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W:0]   ratio_m1;
  logic             full;

  assign ratio_m1 = ({{PRE_W{1'b0}}, 1'b1} << shift_i) - 1'b1;
  assign full     = ({1'b0, cnt_q} >= ratio_m1);
  assign tick_o   = ev_i & full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (ev_i) cnt_q <= full ? '0 : cnt_q + 1'b1;
  end

  AST_PRE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)) else $error("prescaler not cleared"); // R6
endmodule

// File: rtl/tw_wdt.sv
module tw_wdt #(
  parameter int WDT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic clr_i,
  output logic timeout_o,
  output logic pulse_o
);
  logic [WDT_W-1:0] cnt_q;

  assign timeout_o = ev_i & (&cnt_q) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= timeout_o;
      if (clr_i)     cnt_q <= '0;
      else if (ev_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_WDT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !pulse_o)) else $error("clear lost"); // R10
  AST_WDT_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o) else $error("pulse too long"); // R9
endmodule

// File: rtl/tmr_wdt_top.sv
module tmr_wdt_top
  import tmr_wdt_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int PS_W  = 3,
  parameter int WDT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             icyc_tick_i,
  input  logic             ext_pin_i,
  input  logic             wdt_tick_i,
  input  logic             clr_wdt_i,
  input  logic             sleep_i,
  input  logic             mode_we_i,
  input  logic [7:0]       mode_wdata_i,
  output logic [7:0]       mode_o,
  input  logic             tmr_we_i,
  input  logic [TMR_W-1:0] tmr_wdata_i,
  output logic [TMR_W-1:0] tmr_o,
  input  logic             ovf_clr_i,
  output logic             ovf_flag_o,
  output logic             wdt_rst_o,
  output logic             to_n_o,
  output logic             pd_n_o
);
  localparam int PRE_W = 1 << PS_W;
  localparam int SH_W  = $clog2(PRE_W + 1);

  mode_t            mode_q;
  logic [TMR_W-1:0] tmr_q;
  logic             ext_edge, src_ev, pre_ev, pre_clr, pre_tick;
  logic             tmr_inc, wdt_ev, wdt_clr, wdt_to;
  logic [SH_W-1:0]  pre_shift;

  tw_edge_sync u_sync (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .fall_sel_i(mode_q.fall_edge), .edge_o(ext_edge)
  );

  assign src_ev    = mode_q.src_ext ? ext_edge : icyc_tick_i;
  assign pre_ev    = mode_q.pre_wdt ? wdt_tick_i : src_ev;
  assign wdt_clr   = clr_wdt_i | sleep_i;
  assign pre_clr   = tmr_we_i | (mode_q.pre_wdt & wdt_clr);
  // timer ratio table sits one power of two above the watchdog table
  assign pre_shift = SH_W'(mode_q.ps) + (mode_q.pre_wdt ? SH_W'(0) : SH_W'(1));

  tw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .ev_i(pre_ev), .clr_i(pre_clr), .shift_i(pre_shift), .tick_o(pre_tick)
  );

  assign tmr_inc = mode_q.pre_wdt ? src_ev : pre_tick;
  assign wdt_ev  = mode_q.pre_wdt ? pre_tick : wdt_tick_i;

  tw_wdt #(.WDT_W(WDT_W)) u_wdt (
    .clk_i, .rst_ni, .ev_i(wdt_ev), .clr_i(wdt_clr), .timeout_o(wdt_to), .pulse_o(wdt_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= mode_t'(MODE_RST);
    else if (wdt_to)    mode_q <= mode_t'(MODE_RST);
    else if (mode_we_i) mode_q <= mode_t'(mode_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q      <= '0;
      ovf_flag_o <= 1'b0;
    end else begin
      if (tmr_we_i)     tmr_q <= tmr_wdata_i;
      else if (tmr_inc) tmr_q <= tmr_q + 1'b1;
      if (tmr_inc && !tmr_we_i && (&tmr_q)) ovf_flag_o <= 1'b1;
      else if (ovf_clr_i)                   ovf_flag_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_n_o <= 1'b1;
      pd_n_o <= 1'b1;
    end else if (clr_wdt_i) begin
      to_n_o <= 1'b1;
      pd_n_o <= 1'b1;
    end else if (sleep_i) begin
      to_n_o <= 1'b1;
      pd_n_o <= 1'b0;
    end else if (wdt_to) begin
      to_n_o <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign tmr_o  = tmr_q;

  AST_TMR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_we_i |=> (tmr_o == $past(tmr_wdata_i))) else $error("write lost"); // R6
  AST_DIRECT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.pre_wdt && src_ev && !tmr_we_i) |=> (tmr_o == $past(tmr_o) + 1'b1))
    else $error("direct increment missed"); // R4
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_inc && !tmr_we_i && tmr_o == '1) |=> ovf_flag_o) else $error("wrap flag missed"); // R7
  AST_MODE_ON_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (mode_o == MODE_RST && !to_n_o)) else $error("timeout side effects"); // R9
endmodule

// File: tb/tmr_wdt_top_test.sv
module tmr_wdt_top_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic icyc_tick_i = 0, ext_pin_i = 0, wdt_tick_i = 0, clr_wdt_i = 0, sleep_i = 0;
  logic mode_we_i = 0, tmr_we_i = 0, ovf_clr_i = 0;
  logic [7:0] mode_wdata_i = 0, tmr_wdata_i = 0, mode_o, tmr_o;
  logic ovf_flag_o, wdt_rst_o, to_n_o, pd_n_o;
  int n_chk = 0, n_fail = 0, pulses = 0;

  always #10 clk_i = ~clk_i;

  tmr_wdt_top uut (.*);

  always @(negedge clk_i) if (rst_ni && wdt_rst_o) pulses++;

  // {mode, source ticks, expected timer}
  localparam logic [31:0] VEC [7] = '{
    {8'h00, 16'd10,  8'd5},   // R3 1:2
    {8'h01, 16'd10,  8'd2},   // R3 1:4
    {8'h02, 16'd20,  8'd2},   // R3 1:8
    {8'h05, 16'd200, 8'd3},   // R3 1:64
    {8'h07, 16'd600, 8'd2},   // R3 1:256
    {8'h08, 16'd37,  8'd37},  // R4
    {8'h0B, 16'd5,   8'd5}    // R4
  };

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_mode(logic [7:0] v);
    @(negedge clk_i); mode_we_i = 1; mode_wdata_i = v;
    @(negedge clk_i); mode_we_i = 0;
  endtask

  task automatic wr_tmr(logic [7:0] v);
    @(negedge clk_i); tmr_we_i = 1; tmr_wdata_i = v;
    @(negedge clk_i); tmr_we_i = 0;
  endtask

  task automatic icyc(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_i); icyc_tick_i = 1; end
    @(negedge clk_i); icyc_tick_i = 0;
  endtask

  task automatic wtick(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_i); wdt_tick_i = 1; end
    @(negedge clk_i); wdt_tick_i = 0;
  endtask

  task automatic strobe_clr();
    @(negedge clk_i); clr_wdt_i = 1;
    @(negedge clk_i); clr_wdt_i = 0;
  endtask

  task automatic pin(logic v);
    @(negedge clk_i); ext_pin_i = v;
    repeat (5) @(negedge clk_i);
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 mode", mode_o, 8'hFF);
    chk("R1 tmr", tmr_o, 8'h00);
    chk("R1 flags", {4'b0, ovf_flag_o, wdt_rst_o, to_n_o, pd_n_o}, 8'h03);

    foreach (VEC[i]) begin
      wr_mode(VEC[i][31:24]);
      chk("R2 mode readback", mode_o, VEC[i][31:24]);
      wr_tmr(8'h00);
      icyc(int'(VEC[i][23:8]));
      chk(VEC[i][27] ? "R4 direct count" : "R3 prescaled count", tmr_o, VEC[i][7:0]);
    end

    // R6 write clears prescaler: 1:4, three ticks then write
    wr_mode(8'h01); wr_tmr(8'h00); icyc(3);
    wr_tmr(8'h10); icyc(1);
    chk("R6 prescaler cleared by write", tmr_o, 8'h10);
    icyc(3);
    chk("R6 count after clear", tmr_o, 8'h11);

    // R6 write and increment together
    wr_mode(8'h08);
    @(negedge clk_i); icyc_tick_i = 1; tmr_we_i = 1; tmr_wdata_i = 8'h40;
    @(negedge clk_i); icyc_tick_i = 0; tmr_we_i = 0;
    chk("R6 write beats increment", tmr_o, 8'h40);

    // R7 wrap and flag
    wr_tmr(8'hFE); icyc(2);
    chk("R7 wrapped value", tmr_o, 8'h00);
    chk("R7 flag set", {7'b0, ovf_flag_o}, 8'h01);
    @(negedge clk_i); ovf_clr_i = 1;
    @(negedge clk_i); ovf_clr_i = 0;
    chk("R7 flag cleared", {7'b0, ovf_flag_o}, 8'h00);
    wr_tmr(8'hFF);
    @(negedge clk_i); icyc_tick_i = 1; ovf_clr_i = 1;
    @(negedge clk_i); icyc_tick_i = 0; ovf_clr_i = 0;
    chk("R7 set beats clear", {7'b0, ovf_flag_o}, 8'h01);

    // R5 external rising edges
    wr_mode(8'h28); wr_tmr(8'h00);
    pin(1); pin(0); pin(1);
    chk("R5 rising edges counted", tmr_o, 8'h02);
    wr_mode(8'h38); wr_tmr(8'h00);
    pin(0); pin(1);
    chk("R5 falling edge only", tmr_o, 8'h01);
    pin(0);
    chk("R5 second falling edge", tmr_o, 8'h02);

    // R9 watchdog raw ticks (timer owns prescaler)
    wr_mode(8'h00); strobe_clr();
    p0 = pulses;
    wtick(15);
    chk("R9 no early timeout", 8'(pulses - p0), 8'd0);
    wtick(1);
    chk("R9 pulse high", {7'b0, wdt_rst_o}, 8'h01);
    chk("R9 mode reset", mode_o, 8'hFF);
    chk("R9 timeout status", {7'b0, to_n_o}, 8'h00);
    @(negedge clk_i);
    chk("R9 single pulse", 8'(pulses - p0), 8'd1);

    // R10 clear meets final tick
    wr_mode(8'h00);
    p0 = pulses;
    wtick(15);
    @(negedge clk_i); wdt_tick_i = 1; clr_wdt_i = 1;
    @(negedge clk_i); wdt_tick_i = 0; clr_wdt_i = 0;
    chk("R10 timeout cancelled", 8'(pulses - p0), 8'd0);
    chk("R10 status set", {6'b0, to_n_o, pd_n_o}, 8'h03);
    wtick(15);
    chk("R10 counter restarted", 8'(pulses - p0), 8'd0);
    wtick(1); @(negedge clk_i);
    chk("R10 full window then pulse", 8'(pulses - p0), 8'd1);

    // R8 watchdog owns prescaler, 1:4
    wr_mode(8'h0A); strobe_clr();
    p0 = pulses;
    wtick(63);
    chk("R8 prescaled no timeout", 8'(pulses - p0), 8'd0);
    wtick(1); @(negedge clk_i);
    chk("R8 prescaled timeout", 8'(pulses - p0), 8'd1);

    // R11 sleep
    @(negedge clk_i); sleep_i = 1;
    @(negedge clk_i); sleep_i = 0;
    chk("R11 sleep status", {6'b0, to_n_o, pd_n_o}, 8'h02);
    strobe_clr();
    chk("R10 clear after sleep", {6'b0, to_n_o, pd_n_o}, 8'h03);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule